// File: doc/BRIEF.md
# Periodic and Pin-Triggered Register Update Strobe

This block produces the strobe that moves buffered programming words into the active registers of a synthesizer core. It has two sources for that strobe, chosen by a mode bit that the block holds itself. In internal mode a down counter that advances on every second system clock produces a transfer at a programmed interval. Each transfer is also announced on a shared, bidirectional update pin as a stretched high pulse.

In external mode the block releases the pin and watches it. A low-to-high edge on the pin passes through a two-stage synchronizer and an edge detector. It then yields exactly one transfer pulse in the system clock domain, so a transfer never catches registers halfway through a load. The register file that consumes the strobe lies outside this block.

Top module: `upd_strobe_gen`

## Requirements
- R1: After reset the block is in internal mode: `pin_oe` is 1 and `xfer` pulses come from the interval counter without any mode write.
- R2: In internal mode, with interval value n held constant, successive `xfer` pulses are exactly 2*(n+1) clocks apart.
- R3: `xfer` is high for exactly one clock per transfer.
- R4: A write of interval n (`iv_wr` high for one clock) reloads the counter. The next `xfer` becomes visible 2n+2 or 2n+3 clocks after that write edge; which one depends on the phase of the half-rate tick.
- R5: In internal mode with n >= 5, `pin_out` rises in the same cycle as each `xfer` and stays high for exactly 8 clocks.
- R6: In internal mode with n < 5, `pin_out` stays high continuously, while `xfer` still pulses every 2*(n+1) clocks.
- R7: Writing `sel_din`=0 with `sel_wr` selects external mode. In that mode `pin_oe` and `pin_out` are 0 and the interval counter produces no `xfer`.
- R8: In external mode a low-to-high change of `pin_in` produces one `xfer` pulse, visible after the third rising clock edge that follows the change. It stays single even if the pin remains high.
- R9: In external mode a falling edge or a steady level on `pin_in` produces no `xfer`.
- R10: Writing `sel_din`=1 with `sel_wr` returns the block to internal mode. It drives the pin again and resumes periodic transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Write strobe for the mode bit |
| sel_din | input | 1 | New mode bit: 1 internal, 0 external |
| iv_wr | input | 1 | Write strobe for the interval value; reloads the counter |
| iv_val | input | CNT_W | Programmed interval n |
| pin_in | input | 1 | Level sensed on the update pin |
| pin_out | output | 1 | Value driven onto the update pin |
| pin_oe | output | 1 | Drive enable for the update pin |
| xfer | output | 1 | One-clock register transfer pulse |

## Verification
The hardest case to reach is the handover between the two modes. A pulse in flight on the pin, or a pin level left over from internal mode, must not turn into a spurious edge once the pin is released. The bench first runs internal mode with a short interval, so the pin is held high. It then switches to external mode with the outside driver low, which leaves only a falling level in the synchronizer. It checks that no transfer appears before it applies a real rising edge. Because the tick phase relative to a write is not visible at the ports, the reload check accepts the two possible arrival cycles, while the period checks measure between pulses.

// File: rtl/upd_strobe_gen.sv
module upd_strobe_gen #(
  parameter int CNT_W      = 32,
  parameter int PULSE_LEN  = 8,
  parameter int HOLD_LIMIT = 5,
  localparam int STR_W     = $clog2(PULSE_LEN + 1),
  localparam int RUN_W     = STR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic             sel_din,
  input  logic             iv_wr,
  input  logic [CNT_W-1:0] iv_val,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             xfer
);

  logic             sel_q;
  logic             ph;
  logic [CNT_W-1:0] cnt;
  logic [STR_W-1:0] str;
  logic [2:0]       sync_q;
  logic             xfer_q;

  wire low_iv   = iv_val < CNT_W'(HOLD_LIMIT);
  wire fire     = sel_q && ph && (cnt == '0) && !iv_wr;
  wire ext_edge = !sel_q && sync_q[1] && !sync_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      ph     <= 1'b0;
      cnt    <= '0;
      str    <= '0;
      sync_q <= '0;
      xfer_q <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= sel_din;
      ph     <= ~ph;
      sync_q <= {sync_q[1:0], pin_in};
      if (iv_wr)
        cnt <= iv_val;
      else if (sel_q && ph)
        cnt <= (cnt == '0) ? iv_val : cnt - 1'b1;
      if (fire)
        str <= STR_W'(PULSE_LEN);
      else if (str != '0)
        str <= str - 1'b1;
      xfer_q <= fire || ext_edge;
    end
  end

  assign pin_oe  = sel_q;
  assign pin_out = sel_q && (str != '0 || low_iv);
  assign xfer    = xfer_q;

  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)
      run <= '0;
    else if (pin_out && !low_iv)
      run <= (run == '1) ? run : run + 1'b1;
    else
      run <= '0;
  end

  assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && $stable(sel_q)) |=> !xfer);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(PULSE_LEN));

  assert_pin_with_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && sel_q && $past(sel_q)) |-> pin_out);

  assert_released_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

endmodule

// File: tb/upd_strobe_gen_test.sv
module upd_strobe_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0, sel_din = 1'b1, iv_wr = 1'b0;
  logic [31:0] iv_val = 32'd6;
  logic        ext_drv = 1'b0;
  logic        pin_out, pin_oe, xfer;
  wire         pin_in = pin_oe ? pin_out : ext_drv;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  upd_strobe_gen uut (.clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_din(sel_din),
    .iv_wr(iv_wr), .iv_val(iv_val), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .xfer(xfer));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_xfer(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!xfer && c < 5000);
  endtask

  task automatic write_iv(input int n);
    iv_val = n; iv_wr = 1'b1;
    @(negedge clk); iv_wr = 1'b0;
  endtask

  task automatic write_sel(input bit v);
    sel_din = v; sel_wr = 1'b1;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic t_reset;
    int c;
    chk("R1 pin_oe after reset", pin_oe, 1);
    wait_xfer(c);
    chk("R1 xfer without mode write", xfer, 1);
  endtask

  task automatic t_period(input int n);
    int c;
    write_iv(n);
    wait_xfer(c);
    wait_xfer(c);
    chk("R2 period", c, 2 * (n + 1));
    @(negedge clk);
    chk("R3 xfer one clock", xfer, 0);
  endtask

  task automatic t_reload(input int n);
    int c;
    bit ok;
    write_iv(20);
    wait_xfer(c);
    repeat (7) @(negedge clk);
    iv_val = n; iv_wr = 1'b1;
    c = 0;
    do begin @(negedge clk); iv_wr = 1'b0; c++; end while (!xfer && c < 5000);
    ok = (c == 2 * n + 2) || (c == 2 * n + 3);
    chk("R4 first xfer after reload", ok ? 1 : c, 1);
  endtask

  task automatic t_pulse;
    int c, hi;
    write_iv(6);
    wait_xfer(c);
    wait_xfer(c);
    chk("R5 pin high with xfer", pin_out, 1);
    hi = 0;
    while (pin_out && hi < 100) begin hi++; @(negedge clk); end
    chk("R5 pin high time", hi, 8);
  endtask

  task automatic t_hold_high;
    int c, lows;
    write_iv(3);
    wait_xfer(c);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!pin_out) lows++;
    end
    chk("R6 pin never low", lows, 0);
    wait_xfer(c);
    wait_xfer(c);
    chk("R6 period with low interval", c, 8);
  endtask

  task automatic t_ext_enter;
    int xs, drv;
    ext_drv = 1'b0;
    write_sel(1'b0);
    repeat (10) @(negedge clk);
    xs = 0; drv = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (xfer) xs++;
      if (pin_oe || pin_out) drv++;
    end
    chk("R7 no internal xfer", xs, 0);
    chk("R7 pin released", drv, 0);
  endtask

  task automatic t_ext_edge;
    int xs;
    ext_drv = 1'b1;
    @(negedge clk); chk("R8 latency c1", xfer, 0);
    @(negedge clk); chk("R8 latency c2", xfer, 0);
    @(negedge clk); chk("R8 xfer at c3", xfer, 1);
    xs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (xfer) xs++; end
    chk("R8 single xfer while held", xs, 0);
  endtask

  task automatic t_ext_level;
    int xs;
    ext_drv = 1'b0;
    xs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (xfer) xs++; end
    chk("R9 falling edge ignored", xs, 0);
  endtask

  task automatic t_return;
    int c;
    write_iv(9);
    write_sel(1'b1);
    chk("R10 pin driven again", pin_oe, 1);
    wait_xfer(c);
    wait_xfer(c);
    chk("R10 period resumes", c, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_period(0);
    t_period(7);
    t_period(12);
    t_reload(4);
    t_reload(11);
    t_pulse;
    t_hold_high;
    t_ext_enter;
    t_ext_edge;
    t_ext_level;
    t_ext_edge;
    t_ext_level;
    t_return;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule